// File: doc/BRIEF.md
# Divided Countdown Timer

A 32-bit down-counter whose decrement rate is set by a power-of-two prescaler. Software programs a configuration entry with an 8-bit vector, a mask bit and a periodic-mode bit. It also programs a 4-bit divide code and a start value. Writing the start value loads the counter and restarts the prescaler. From then on the count drops by one on every divided tick.

In one-shot mode the count stops at zero. In periodic mode it reloads the start value on the tick after zero, so one period is the start value plus one ticks. Each time the count reaches zero, the block raises a one-cycle expiry pulse and presents the configured vector, provided the entry is unmasked. A start value of zero leaves the timer idle.

The divided tick is also driven out as a clock-enable for neighbouring logic. Interrupt acceptance and address decoding belong to the surrounding logic.

Top module: `cntdown_timer`

## Requirements
- R1: After reset, the counter, start value and divide code read as 0. The configuration word reads 0x0001_0000: vector 0, mask set, one-shot. `expire_o` and `vector_o` are 0.
- R2: The divide register (address 3) keeps only bits 3, 1 and 0 of the written value and reads back as the written value AND 0xB.
- R3: The tick period is 2^e cycles, where e = ({bit3, bit1, bit0} + 1) mod 8. Code 0x0 gives 2, code 0xB gives 1, code 0x3 gives 16 and code 0xA gives 128.
- R4: A write of start value S (address 1) makes the counter (address 2) read S in the next cycle and clears the prescaler. The first decrement lands a full tick period (N cycles) after the write, so the count reads S-k exactly k·N cycles after the write edge.
- R5: In one-shot mode (configuration bit 17 = 0) the count stops at 0 and stays there.
- R6: In periodic mode (bit 17 = 1) the tick that finds the count at 0 reloads the start value. Expiries are therefore S+1 ticks apart.
- R7: When a tick moves the count from 1 to 0 with the mask clear, `expire_o` is high for exactly the one cycle in which the count first reads 0. In that cycle `vector_o` shows the vector held in configuration bits 7:0.
- R8: With the mask (configuration bit 16) set, no expiry pulse is produced, but counting carries on unchanged.
- R9: While the start value is 0, the counter holds at 0 and never raises an expiry.
- R10: The counter register is read-only. A write to address 2 leaves the count unchanged.
- R11: The configuration word (address 0) reads back vector, mask and mode in bits 7:0, 16 and 17. A mode change takes effect from the next tick without restarting the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register select: 0 config, 1 start value, 2 counter, 3 divide |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` (combinational) |
| tick_o | output | 1 | Divided clock-enable tick |
| expire_o | output | 1 | One-cycle expiry pulse |
| vector_o | output | 8 | Vector captured at the last expiry |

## Verification
The bench uses the default 32-bit counter width. It keeps start values small, so every one-shot, periodic and masked countdown fits in a few dozen cycles. The divide codes for 1, 2, 16 and 128 are measured as tick periods. Countdowns run at divide-by-1 and divide-by-2, which makes each expiry cycle computable as the write cycle plus whole tick periods. These settings also cover the wrap from zero, the mid-run switch from periodic to one-shot, and a read-only write during a long countdown.

// File: rtl/tmr_pkg.sv
// Shared definitions for the divided countdown timer.
// Assumes an 8-bit vector field and a 2-bit register address.
package tmr_pkg;
    localparam int VEC_W     = 8;
    localparam int MASK_POS  = 16;      // mask bit in the configuration word
    localparam int MODE_POS  = 17;      // periodic bit in the configuration word
    localparam int DIV_W     = 4;
    localparam logic [DIV_W-1:0] DIV_KEEP = 4'hB;
    localparam int EXP_W     = 3;       // prescaler exponent width
    localparam int PRE_W     = (1 << EXP_W) - 1;  // prescaler counter width

    typedef enum logic [1:0] {
        REG_CFG  = 2'd0,
        REG_INIT = 2'd1,
        REG_CUR  = 2'd2,
        REG_DIV  = 2'd3
    } tmr_reg_e;

    typedef struct packed {
        logic             periodic;
        logic             mask;
        logic [VEC_W-1:0] vec;
    } tmr_cfg_t;
endpackage

// File: rtl/tmr_regs.sv
// Holds the writable timer registers: configuration entry, start value and divide code.
// Produces a load strobe on start-value writes and a prescaler clear on start-value
// or divide writes. Assumes single-cycle writes; the counter address is not stored here.
module tmr_regs
    import tmr_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       addr,
    input  logic [CNT_W-1:0] wdata,
    output tmr_cfg_t         cfg_q,
    output logic [CNT_W-1:0] init_q,
    output logic [DIV_W-1:0] div_q,
    output logic             load,
    output logic             pre_clr
);
    logic wr_cfg, wr_init, wr_div;

    // Decode the write strobe per register.
    always_comb begin
        wr_cfg  = wr_en && (addr == REG_CFG);
        wr_init = wr_en && (addr == REG_INIT);
        wr_div  = wr_en && (addr == REG_DIV);
        load    = wr_init;
        pre_clr = wr_init || wr_div;
    end

    // Register storage with synchronous reset; the entry resets masked.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q  <= '{periodic: 1'b0, mask: 1'b1, vec: '0};
            init_q <= '0;
            div_q  <= '0;
        end else begin
            if (wr_cfg)
                cfg_q <= '{periodic: wdata[MODE_POS], mask: wdata[MASK_POS],
                           vec: wdata[VEC_W-1:0]};
            if (wr_init)
                init_q <= wdata;
            if (wr_div)
                div_q <= wdata[DIV_W-1:0] & DIV_KEEP;
        end
    end

    p_div_unused_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (div_q & ~DIV_KEEP) == '0);
endmodule

// File: rtl/tmr_prescaler.sv
// Power-of-two prescaler. The exponent is formed from divide-code bits 3,1,0 plus
// one, modulo 2^EXP_W, so code 0b1011 divides by 1. The tick is high in the last
// cycle of each period; a clear restarts the period.
module tmr_prescaler
    import tmr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [DIV_W-1:0] div_code,
    output logic             tick
);
    logic [EXP_W-1:0] expo;
    logic [PRE_W-1:0] lim;
    logic [PRE_W-1:0] pre_q;

    // Derive the exponent and the terminal prescaler value from the code.
    always_comb begin
        expo = {div_code[3], div_code[1:0]} + EXP_W'(1);
        lim  = (PRE_W'(1) << expo) - PRE_W'(1);
        tick = (pre_q == lim);
    end

    // Count cycles within a period; restart on clear or at the terminal value.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            pre_q <= '0;
        else if (pre_q == lim)
            pre_q <= '0;
        else
            pre_q <= pre_q + PRE_W'(1);
    end

    p_pre_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pre_q <= lim);
endmodule

// File: rtl/tmr_downcount.sv
// The countdown core. It loads the start value on a load strobe and moves on once
// per tick while the start value is non-zero. It holds at zero in one-shot mode and
// reloads after zero in periodic mode. It pulses expire for one cycle, together with
// the captured vector, when the count reaches zero unmasked.
module tmr_downcount
    import tmr_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] init_val,
    input  logic             tick,
    input  tmr_cfg_t         cfg,
    output logic [CNT_W-1:0] cur_q,
    output logic             expire_q,
    output logic [VEC_W-1:0] vec_q
);
    logic running;

    // The timer is idle while the start value is zero.
    always_comb running = (init_val != '0);

    // Counter, expiry pulse and vector capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q    <= '0;
            expire_q <= 1'b0;
            vec_q    <= '0;
        end else begin
            expire_q <= 1'b0;
            if (load) begin
                cur_q <= load_val;
            end else if (tick && running) begin
                if (cur_q == '0) begin
                    if (cfg.periodic)
                        cur_q <= init_val;
                end else begin
                    cur_q <= cur_q - CNT_W'(1);
                    if (cur_q == CNT_W'(1) && !cfg.mask) begin
                        expire_q <= 1'b1;
                        vec_q    <= cfg.vec;
                    end
                end
            end
        end
    end

    p_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> cur_q == $past(load_val));
    p_hold_no_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !tick) |=> $stable(cur_q));
    p_oneshot_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !cfg.periodic && cur_q == '0) |=> cur_q == '0);
    p_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && tick && running && cfg.periodic && cur_q == '0) |=> cur_q == $past(init_val));
    p_expire_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        expire_q |-> cur_q == '0);
    p_expire_unmasked_r8: assert property (@(posedge clk) disable iff (!rst_n)
        expire_q |-> !$past(cfg.mask));
    p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !load) |=> (!expire_q && $stable(cur_q)));
endmodule

// File: rtl/cntdown_timer.sv
// Top of the divided countdown timer. It joins the register file, the prescaler
// and the countdown core, and provides the read mux. The counter address is
// read-only. Assumes CNT_W is at least MODE_POS+1 so the configuration word fits.
module cntdown_timer
    import tmr_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       addr,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] rdata,
    output logic             tick_o,
    output logic             expire_o,
    output logic [VEC_W-1:0] vector_o
);
    tmr_cfg_t         cfg_q;
    logic [CNT_W-1:0] init_q;
    logic [CNT_W-1:0] cur_q;
    logic [DIV_W-1:0] div_q;
    logic             load, pre_clr, tick;

    tmr_regs #(.CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .cfg_q(cfg_q), .init_q(init_q), .div_q(div_q), .load(load), .pre_clr(pre_clr)
    );

    tmr_prescaler u_pre (
        .clk(clk), .rst_n(rst_n), .clr(pre_clr), .div_code(div_q), .tick(tick)
    );

    tmr_downcount #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .load(load), .load_val(wdata), .init_val(init_q),
        .tick(tick), .cfg(cfg_q), .cur_q(cur_q), .expire_q(expire_o), .vec_q(vector_o)
    );

    // Drive the tick out as a clock-enable.
    always_comb tick_o = tick;

    // Read mux; the configuration fields return at their write positions.
    always_comb begin
        rdata = '0;
        case (addr)
            REG_CFG: begin
                rdata[VEC_W-1:0] = cfg_q.vec;
                rdata[MASK_POS]  = cfg_q.mask;
                rdata[MODE_POS]  = cfg_q.periodic;
            end
            REG_INIT: rdata = init_q;
            REG_CUR:  rdata = cur_q;
            default:  rdata[DIV_W-1:0] = div_q;
        endcase
    end

    p_cur_readonly_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == REG_CUR && !tick) |=> $stable(cur_q));
endmodule

// File: tb/tb_cntdown_timer.sv
`timescale 1ns/1ps
module tb_cntdown_timer;
    import tmr_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        tick_o, expire_o;
    logic [7:0]  vector_o;

    cntdown_timer dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .tick_o(tick_o), .expire_o(expire_o), .vector_o(vector_o)
    );

    always #10 clk = ~clk;   // 50 MHz

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_chk = 0, n_bad = 0, n_unexp = 0;
    bit done = 0;

    typedef struct { int at; logic [7:0] vec; } exp_t;
    exp_t sbq[$];

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    endtask

    // Driver: a single register write; returns the cycle count after the capturing edge.
    task automatic wr(input logic [1:0] a, input logic [31:0] d, output int w);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk); #1;
        w = cyc;
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        addr = a; #1; d = rdata;
    endtask

    task automatic wait_cyc(input int n);
        @(negedge clk);
        while (cyc < n) @(negedge clk);
    endtask

    task automatic push_exp(input int at, input logic [7:0] v);
        exp_t e;
        e.at = at; e.vec = v;
        sbq.push_back(e);
    endtask

    // Monitor: compare each expiry pulse against the front of the scoreboard.
    always @(negedge clk) begin
        exp_t e;
        if (rst_n && expire_o) begin
            if (sbq.size() == 0) begin
                n_chk++; n_bad++; n_unexp++;
                $display("FAIL R7: unexpected expiry at cycle %0d vector %0h, expected none",
                         cyc, vector_o);
            end else begin
                e = sbq.pop_front();
                chk("R7 expiry cycle", cyc, e.at);
                chk("R7 vector", {24'd0, vector_o}, {24'd0, e.vec});
            end
        end
    end

    task automatic measure(input logic [3:0] code, input int per);
        int w, t1;
        wr(REG_DIV, {28'd0, code}, w);
        @(negedge clk);
        while (!tick_o) @(negedge clk);
        t1 = cyc;
        @(negedge clk);
        while (!tick_o) @(negedge clk);
        chk($sformatf("R3 tick period code %0h", code), cyc - t1, per);
    endtask

    initial begin
        #4_000_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        finish_run();
    end

    initial begin
        logic [31:0] d;
        int w, base;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        rd(REG_CFG, d);  chk("R1 cfg", d, 32'h0001_0000);
        rd(REG_INIT, d); chk("R1 init", d, 0);
        rd(REG_CUR, d);  chk("R1 cur", d, 0);
        rd(REG_DIV, d);  chk("R1 div", d, 0);
        chk("R1 expire", {31'd0, expire_o}, 0);
        chk("R1 vector", {24'd0, vector_o}, 0);

        // R2 divide storage
        wr(REG_DIV, 32'hFFFF_FFFF, w); @(negedge clk); rd(REG_DIV, d); chk("R2 div 0xF", d, 32'hB);
        wr(REG_DIV, 32'h4, w);         @(negedge clk); rd(REG_DIV, d); chk("R2 div 0x4", d, 32'h0);

        // R3 ratios
        measure(4'h0, 2);
        measure(4'hB, 1);
        measure(4'h3, 16);
        measure(4'hA, 128);

        // R11 configuration readback
        wr(REG_CFG, 32'h0002_00C3, w); @(negedge clk); rd(REG_CFG, d); chk("R11 cfg readback", d, 32'h0002_00C3);

        // R4 R5 R7 one-shot at divide-by-2
        wr(REG_DIV, 32'h0, w);
        wr(REG_CFG, 32'h0000_005A, w);
        wr(REG_INIT, 32'd5, base);
        push_exp(base + 10, 8'h5A);
        @(negedge clk); rd(REG_CUR, d); chk("R4 loaded", d, 5);
        wait_cyc(base + 1); rd(REG_CUR, d); chk("R4 no early decrement", d, 5);
        wait_cyc(base + 2); rd(REG_CUR, d); chk("R4 first decrement", d, 4);
        wait_cyc(base + 30); rd(REG_CUR, d); chk("R5 holds at zero", d, 0);
        chk("R7 scoreboard drained", sbq.size(), 0);

        // R6 periodic at divide-by-1, then R9 stop
        wr(REG_DIV, 32'hB, w);
        wr(REG_CFG, 32'h0002_0033, w);
        wr(REG_INIT, 32'd3, base);
        push_exp(base + 3, 8'h33); push_exp(base + 7, 8'h33); push_exp(base + 11, 8'h33);
        wait_cyc(base + 4); rd(REG_CUR, d); chk("R6 wrap to start", d, 3);
        wait_cyc(base + 12);
        wr(REG_INIT, 32'd0, w);
        chk("R6 three expiries", sbq.size(), 0);
        base = n_unexp;
        wait_cyc(w + 20); rd(REG_CUR, d); chk("R9 idle count", d, 0);
        chk("R9 no expiry when idle", n_unexp - base, 0);

        // R8 masked one-shot keeps counting
        wr(REG_CFG, 32'h0001_0077, w);
        base = n_unexp;
        wr(REG_INIT, 32'd4, w);
        wait_cyc(w + 2); rd(REG_CUR, d); chk("R8 counting while masked", d, 2);
        wait_cyc(w + 12); rd(REG_CUR, d); chk("R8 reached zero", d, 0);
        chk("R8 no pulse", n_unexp - base, 0);

        // R10 write to counter ignored
        wr(REG_CFG, 32'h0001_0000, w);
        wr(REG_INIT, 32'd100, base);
        wait_cyc(base + 5);
        wr(REG_CUR, 32'd7, w);
        @(negedge clk); rd(REG_CUR, d); chk("R10 read-only counter", d, 100 - (cyc - base));

        // R11 mode change mid-run: periodic to one-shot
        wr(REG_CFG, 32'h0002_0021, w);
        wr(REG_INIT, 32'd2, base);
        push_exp(base + 2, 8'h21); push_exp(base + 5, 8'h21);
        wait_cyc(base + 3);
        wr(REG_CFG, 32'h0000_0021, w);
        wait_cyc(base + 20); rd(REG_CUR, d); chk("R11 one-shot after switch", d, 0);
        chk("R11 expiries after switch", sbq.size(), 0);
        wr(REG_INIT, 32'd0, w);
        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule